// File: doc/BRIEF.md
# Multi-Source Condition Flags Register

This block holds the carry and zero condition bits of a small processor. Three units can report these bits: the arithmetic unit and two loop-counter registers. Each unit drives its own carry and zero outputs. It also has its own capture strobe, which says that this unit should write the flags in the current cycle.

On each rising clock edge, each unit's carry and zero are masked by that unit's strobe. The masked bits are merged with a bitwise OR, carry with carry and zero with zero. The flags register loads the merged pair only when at least one strobe is high. When no strobe is high, the register keeps its value. A unit that is not selected therefore cannot change the flags, even if it holds a zero value.

Top module: `cond_flags_mux`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears both flag outputs to 0.
- R2: Flags change only on a rising clock edge, one cycle after the strobes and source flags are presented.
- R3: When no capture strobe is high at a rising edge, both flag outputs keep their previous values.
- R4: When exactly one strobe is high, the next flag_c and flag_z equal that source's carry and zero inputs.
- R5: The carry and zero inputs of a source whose strobe is low have no effect on the flags. For example, an idle counter reporting zero does not set flag_z while the arithmetic unit reports a non-zero result.
- R6: When several strobes are high, each loaded flag is the OR of that flag across the enabled sources.
- R7: Carry and zero are handled independently: the carry output never depends on any zero input, and the zero output never depends on any carry input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_c | input | NSRC | Carry per source (bit 0 arithmetic unit, bit 1 counter I, bit 2 counter J) |
| src_z | input | NSRC | Zero per source (same bit order as src_c) |
| src_en | input | NSRC | Capture strobe per source (same bit order) |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
The assertions check three things on every cycle: the hold rule when all strobes are low, the masking by the strobe on each flag, and the reset value. Each of these compares the flags against the inputs sampled one edge earlier. Only the bench scenarios can show that a single flag pattern is taken from the right source among idle sources that present conflicting values. The same is true for the OR merge when strobes overlap, and for state persisting across long idle stretches after a load.

// File: rtl/cond_flags_mux.sv
module cond_flags_mux #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_c,
  input  logic [NSRC-1:0] src_z,
  input  logic [NSRC-1:0] src_en,
  output logic            flag_c,
  output logic            flag_z
);

  logic any_en;
  logic nxt_c;
  logic nxt_z;

  assign any_en = |src_en;
  assign nxt_c  = |(src_c & src_en);
  assign nxt_z  = |(src_z & src_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else if (any_en) begin
      flag_c <= nxt_c;
      flag_z <= nxt_z;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) past_ok && $past(rst) |-> !flag_c && !flag_z); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(src_en) == '0 |-> $stable(flag_c) && $stable(flag_z)); // R3
  AST_MASKED_CARRY: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(src_en) != '0 |-> flag_c == ($past(src_c & src_en) != '0)); // R5
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(src_en) != '0 |-> flag_z == ($past(src_z & src_en) != '0)); // R7

endmodule

// File: tb/sim_cond_flags_mux.sv
`timescale 1ns/1ps
module sim_cond_flags_mux;
  localparam int N = 3;
  logic clk = 0;
  logic rst;
  logic [N-1:0] c, z, en;
  logic fc, fz;
  int checks = 0, errors = 0;
  bit  mc, mz;

  always #4 clk = ~clk;

  cond_flags_mux #(.NSRC(N)) u0 (.clk(clk), .rst(rst), .src_c(c), .src_z(z),
    .src_en(en), .flag_c(fc), .flag_z(fz));

  task automatic chk(input string tag);
    checks++;
    if (fc !== mc || fz !== mz) begin
      errors++;
      $display("FAIL %s c/z actual %b%b expected %b%b", tag, fc, fz, mc, mz);
    end
  endtask

  task automatic step(input logic r, input logic [N-1:0] ci, zi, ei, input string tag);
    rst = r; c = ci; z = zi; en = ei;
    @(posedge clk);
    if (r) begin mc = 0; mz = 0; end
    else if (ei != 0) begin
      mc = 0; mz = 0;
      for (int i = 0; i < N; i++) if (ei[i]) begin mc |= ci[i]; mz |= zi[i]; end
    end
    #2 chk(tag);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; c = '1; z = '1; en = '1; mc = 0; mz = 0;
    step(1, '1, '1, '1, "R1 reset");
    step(0, 3'b001, 3'b000, 3'b001, "R4 alu carry");
    step(0, 3'b111, 3'b111, 3'b000, "R3 hold idle");
    step(0, 3'b000, 3'b110, 3'b001, "R5 idle zero ignored");
    step(0, 3'b010, 3'b000, 3'b010, "R4 counter I carry");
    step(0, 3'b000, 3'b100, 3'b100, "R4 counter J zero");
    step(0, 3'b011, 3'b011, 3'b100, "R5 idle sources ignored");
    step(0, 3'b000, 3'b000, 3'b000, "R3 hold");
    step(0, 3'b001, 3'b100, 3'b101, "R6 or merge");
    step(0, 3'b000, 3'b111, 3'b010, "R7 zero only");
    step(0, 3'b111, 3'b000, 3'b001, "R7 carry only");
    rst = 0; en = 0; c = '1; z = '1;
    #1 checks++;
    if (fc !== mc || fz !== mz) begin errors++; $display("FAIL R2 mid-cycle change %b%b exp %b%b", fc, fz, mc, mz); end
    step(1, '1, '1, '1, "R1 reset again");
    for (int k = 0; k < 40; k++) step(0, 3'(k), 3'(k*5+1), 3'(k/3), "R6 sweep");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule